// File: doc/BRIEF.md
# Sequential Sign-Magnitude Fraction Divider

The block divides one sign-magnitude fixed-point fraction by another, one quotient bit per clock. Each operand arrives as a sign bit and a `W`-bit magnitude with weight 2^-1 for its top bit. The dividend magnitude must be strictly smaller than the divisor magnitude, so the quotient is a proper fraction. The quotient sign is the exclusive-or of the two operand signs, and the magnitudes are divided separately.

The partial remainder is never restored. While the remainder is negative, the next step doubles it and adds the divisor. While it is zero or positive, the next step doubles it and subtracts the divisor. This works because doubling (R - Y) and then adding Y gives the same value as doubling R and then subtracting Y.

The first subtraction yields a quotient bit that is always zero, because the dividend is smaller than the divisor. That bit position carries the quotient sign in the packed result. After the last step, one corrective addition makes a negative remainder non-negative. Operands that break the precondition, including a zero divisor, are refused at once with an error flag.

Top module: `nrfrac_div`

## Requirements
- R1: If the divisor magnitude is zero, or the dividend magnitude is greater than or equal to the divisor magnitude, the start is refused. On the first clock edge after the start edge, `done_o` and `err_o` are 1, `quo_o` is 0, `rem_o` is 0, and `busy_o` never rises.
- R2: For a valid start, `quo_o[W-1:0]` equals floor(dvd_mag * 2^W / dvs_mag). In internal state, the first quotient bit produced is always 0.
- R3: For a valid start, `quo_o[W]` (the top bit) equals `dvd_sign_i ^ dvs_sign_i`. This holds even when the quotient magnitude is zero.
- R4: For a valid start, `rem_o` equals dvd_mag * 2^W - q * dvs_mag, where q is the quotient magnitude. It is always smaller than the divisor magnitude. Its weight is 2^-2W.
- R5: For a valid start, `busy_o` is 1 for W+1 cycles. `done_o` rises on the (W+2)-th rising edge, counting the edge that sampled `start_i` as the first.
- R6: `done_o` is a single-cycle pulse for each accepted start. `busy_o` and `done_o` are never 1 together. `err_o` is 0 after any valid operation.
- R7: `start_i` is ignored while `busy_o` is 1. The result belongs to the operands sampled when the operation was accepted.
- R8: While `rst_ni` is low, `busy_o`, `done_o`, `err_o`, `quo_o` and `rem_o` are 0.
- R9: `quo_o`, `rem_o` and `err_o` hold their values from completion until the next accepted start, and they do not change while `busy_o` is 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| start_i | input | 1 | Begin a division; sampled when not busy |
| dvd_sign_i | input | 1 | Dividend sign (1 = negative) |
| dvd_mag_i | input | W | Dividend magnitude, fraction |
| dvs_sign_i | input | 1 | Divisor sign (1 = negative) |
| dvs_mag_i | input | W | Divisor magnitude, fraction |
| busy_o | output | 1 | Division in progress |
| done_o | output | 1 | One-cycle completion pulse |
| err_o | output | 1 | Precondition failed; result is zero |
| quo_o | output | W+1 | Packed quotient: sign at top, magnitude below |
| rem_o | output | W | Final non-negative remainder magnitude |

## Verification
A wrong add-or-subtract choice, or a wrong quotient bit in any step, corrupts every later remainder. Such a fault shows up at completion, W+2 edges after start, as a quotient and remainder that break q*Y + r = R*2^W. Every operand pair at the bench width is therefore compared, so a step fault that depends on the data cannot hide. A counter or state fault shows as a shifted `done_o` edge, a `busy_o` that overlaps `done_o`, or outputs that move while busy. A precondition fault shows one edge after start as a wrong `err_o`.

// File: rtl/nrfrac_div_pkg.sv
package nrfrac_div_pkg;
  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_RUN  = 2'd1,
    ST_FIX  = 2'd2
  } nrdiv_state_e;
endpackage

// File: rtl/nrfrac_div_guard.sv
module nrfrac_div_guard #(
  parameter int W = 8
) (
  input  logic [W-1:0] dvd_mag_i,
  input  logic [W-1:0] dvs_mag_i,
  output logic         bad_o
);
  always_comb begin
    bad_o = (dvs_mag_i == '0) || (dvd_mag_i >= dvs_mag_i);
  end
endmodule

// File: rtl/nrfrac_div_step.sv
// One non-restoring step: double the remainder, then add or subtract the divisor by its sign.
module nrfrac_div_step #(
  parameter int W = 8
) (
  input  logic [W+1:0] rem_i,
  input  logic [W-1:0] dvs_i,
  output logic [W+1:0] rem_o,
  output logic         qbit_o
);
  localparam int RW = W + 2;

  logic [RW-1:0] dbl;
  logic [RW-1:0] dvs_ext;

  always_comb begin
    dbl     = {rem_i[RW-2:0], 1'b0};
    dvs_ext = {2'b00, dvs_i};
    if (rem_i[RW-1]) rem_o = dbl + dvs_ext;
    else             rem_o = dbl - dvs_ext;
    qbit_o = ~rem_o[RW-1];
  end
endmodule

// File: rtl/nrfrac_div_ctrl.sv
module nrfrac_div_ctrl
  import nrfrac_div_pkg::*;
#(
  parameter int W = 8
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic start_i,
  input  logic bad_i,
  output logic load_o,
  output logic reject_o,
  output logic step_o,
  output logic fix_o,
  output logic busy_o
);
  localparam int CW = $clog2(W + 1);
  localparam logic [CW-1:0] LAST = CW'(W - 1);

  nrdiv_state_e state_q, state_d;
  logic [CW-1:0] cnt_q, cnt_d;

  always_comb begin
    state_d  = state_q;
    cnt_d    = cnt_q;
    load_o   = 1'b0;
    reject_o = 1'b0;
    step_o   = 1'b0;
    fix_o    = 1'b0;
    unique case (state_q)
      ST_IDLE: begin
        if (start_i) begin
          if (bad_i) reject_o = 1'b1;
          else begin
            load_o  = 1'b1;
            cnt_d   = '0;
            state_d = ST_RUN;
          end
        end
      end
      ST_RUN: begin
        step_o = 1'b1;
        cnt_d  = cnt_q + 1'b1;
        if (cnt_q == LAST) state_d = ST_FIX;
      end
      ST_FIX: begin
        fix_o   = 1'b1;
        state_d = ST_IDLE;
      end
      default: state_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= ST_IDLE;
      cnt_q   <= '0;
    end else begin
      state_q <= state_d;
      cnt_q   <= cnt_d;
    end
  end

  assign busy_o = (state_q != ST_IDLE);
endmodule

// File: rtl/nrfrac_div.sv
module nrfrac_div #(
  parameter int W = 8
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         start_i,
  input  logic         dvd_sign_i,
  input  logic [W-1:0] dvd_mag_i,
  input  logic         dvs_sign_i,
  input  logic [W-1:0] dvs_mag_i,
  output logic         busy_o,
  output logic         done_o,
  output logic         err_o,
  output logic [W:0]   quo_o,
  output logic [W-1:0] rem_o
);
  localparam int RW = W + 2;

  logic          bad;
  logic          load, reject, step_en, fix_en;
  logic [RW-1:0] rem_q, rem_nxt, first_diff, rem_fix;
  logic [W-1:0]  dvs_q;
  logic [W:0]    quo_q;
  logic          sign_q, qbit;

  nrfrac_div_guard #(.W(W)) u_guard (
    .dvd_mag_i (dvd_mag_i),
    .dvs_mag_i (dvs_mag_i),
    .bad_o     (bad)
  );

  nrfrac_div_ctrl #(.W(W)) u_ctrl (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .start_i  (start_i),
    .bad_i    (bad),
    .load_o   (load),
    .reject_o (reject),
    .step_o   (step_en),
    .fix_o    (fix_en),
    .busy_o   (busy_o)
  );

  nrfrac_div_step #(.W(W)) u_step (
    .rem_i  (rem_q),
    .dvs_i  (dvs_q),
    .rem_o  (rem_nxt),
    .qbit_o (qbit)
  );

  always_comb begin
    first_diff = {2'b00, dvd_mag_i} - {2'b00, dvs_mag_i};
    rem_fix    = rem_q[RW-1] ? rem_q + {2'b00, dvs_q} : rem_q;
  end

  // datapath: first subtraction at load, then W steps; top quotient bit is the discarded zero
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      rem_q  <= '0;
      dvs_q  <= '0;
      quo_q  <= '0;
      sign_q <= 1'b0;
    end else if (load) begin
      rem_q  <= first_diff;
      dvs_q  <= dvs_mag_i;
      quo_q  <= {{W{1'b0}}, ~first_diff[RW-1]};
      sign_q <= dvd_sign_i ^ dvs_sign_i;
    end else if (step_en) begin
      rem_q  <= rem_nxt;
      quo_q  <= {quo_q[W-1:0], qbit};
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      done_o <= 1'b0;
      err_o  <= 1'b0;
      quo_o  <= '0;
      rem_o  <= '0;
    end else begin
      done_o <= reject | fix_en;
      if (reject) begin
        err_o <= 1'b1;
        quo_o <= '0;
        rem_o <= '0;
      end else if (load) begin
        err_o <= 1'b0;
      end else if (fix_en) begin
        quo_o <= {sign_q, quo_q[W-1:0]};
        rem_o <= rem_fix[W-1:0];
      end
    end
  end
endmodule

// File: rtl/nrfrac_div_chk.sv
module nrfrac_div_chk #(
  parameter int W = 8
) (
  input logic         clk_i,
  input logic         rst_ni,
  input logic         start_i,
  input logic         busy_o,
  input logic         done_o,
  input logic         err_o,
  input logic [W:0]   quo_o,
  input logic [W-1:0] rem_o,
  input logic [W-1:0] dvs_q,
  input logic [W:0]   quo_q,
  input logic         fix_en
);
  assert_busy_done_excl_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    busy_o |-> !done_o);

  assert_err_zero_R1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (done_o && err_o) |-> (quo_o == '0 && rem_o == '0));

  assert_rem_below_dvs_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (done_o && !err_o) |-> (rem_o < dvs_q));

  assert_first_bit_zero_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    fix_en |-> !quo_q[W]);

  assert_hold_while_busy_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (busy_o && $past(busy_o)) |-> ($stable(quo_o) && $stable(rem_o) && $stable(err_o)));

  assert_idle_start_acts_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (start_i && !busy_o) |=> (busy_o || done_o));

  assert_done_pulse_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (done_o && !err_o) |=> !(done_o && !err_o));
endmodule

bind nrfrac_div nrfrac_div_chk #(.W(W)) u_chk (
  .clk_i   (clk_i),
  .rst_ni  (rst_ni),
  .start_i (start_i),
  .busy_o  (busy_o),
  .done_o  (done_o),
  .err_o   (err_o),
  .quo_o   (quo_o),
  .rem_o   (rem_o),
  .dvs_q   (dvs_q),
  .quo_q   (quo_q),
  .fix_en  (fix_en)
);

// File: tb/tb_nrfrac_div.sv
`timescale 1ns/1ps
module tb_nrfrac_div;
  localparam int W = 6;
  localparam int MAXV = 1 << W;

  logic         clk_i = 1'b0;
  logic         rst_ni = 1'b0;
  logic         start_i = 1'b0;
  logic         dvd_sign_i = 1'b0;
  logic [W-1:0] dvd_mag_i = '0;
  logic         dvs_sign_i = 1'b0;
  logic [W-1:0] dvs_mag_i = '0;
  logic         busy_o, done_o, err_o;
  logic [W:0]   quo_o;
  logic [W-1:0] rem_o;

  int n_chk = 0;
  int n_bad = 0;
  int cyc = 0;
  bit finished = 1'b0;

  always #4 clk_i = ~clk_i;

  nrfrac_div #(.W(W)) dut (
    .clk_i(clk_i), .rst_ni(rst_ni), .start_i(start_i),
    .dvd_sign_i(dvd_sign_i), .dvd_mag_i(dvd_mag_i),
    .dvs_sign_i(dvs_sign_i), .dvs_mag_i(dvs_mag_i),
    .busy_o(busy_o), .done_o(done_o), .err_o(err_o),
    .quo_o(quo_o), .rem_o(rem_o)
  );

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  function automatic bit is_bad(int r, int y);
    return (y == 0) || (r >= y);
  endfunction
  function automatic int exp_q(int r, int y);
    return (r * MAXV) / y;
  endfunction
  function automatic int exp_r(int r, int y);
    return (r * MAXV) % y;
  endfunction

  task automatic summary();
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  endtask

  always @(posedge clk_i) begin
    cyc++;
    if (cyc > 190000 && !finished) begin
      finished = 1'b1;
      chk(1'b0, "watchdog", cyc, 190000);
      summary();
    end
  end

  // full operation; latency counted in rising edges including the start edge
  task automatic run_op(input int r, input int y, input bit sr, input bit sy, input bit overlap);
    int lat;
    bit bad;
    bad = is_bad(r, y);
    @(negedge clk_i);
    start_i = 1'b1; dvd_mag_i = W'(r); dvs_mag_i = W'(y);
    dvd_sign_i = sr; dvs_sign_i = sy;
    @(posedge clk_i);
    @(negedge clk_i);
    lat = 1;
    if (overlap && !bad) begin
      // R7: new operands offered while busy
      start_i = 1'b1; dvd_mag_i = W'(1); dvs_mag_i = W'(MAXV - 1);
      dvd_sign_i = ~sr; dvs_sign_i = sy;
    end else start_i = 1'b0;
    while (!done_o && lat < 100) begin
      if (busy_o) chk(1'b1, "R5", 1, 1);
      if (bad) chk(!busy_o, "R1 busy", busy_o, 0);
      @(posedge clk_i);
      @(negedge clk_i);
      lat++;
      start_i = 1'b0;
    end
    start_i = 1'b0;
    if (bad) begin
      chk(lat == 1, "R1 latency", lat, 1);
      chk(err_o == 1'b1, "R1 err", err_o, 1);
      chk(quo_o == '0 && rem_o == '0, "R1 zero", int'(quo_o), 0);
    end else begin
      chk(lat == W + 2, "R5 latency", lat, W + 2);
      chk(!busy_o, "R6 busy", busy_o, 0);
      chk(err_o == 1'b0, "R6 err", err_o, 0);
      chk(int'(quo_o[W-1:0]) == exp_q(r, y), "R2 quotient", int'(quo_o[W-1:0]), exp_q(r, y));
      chk(quo_o[W] == (sr ^ sy), "R3 sign", quo_o[W], sr ^ sy);
      chk(int'(rem_o) == exp_r(r, y), "R4 remainder", int'(rem_o), exp_r(r, y));
      @(negedge clk_i);
      chk(!done_o, "R6 pulse", done_o, 0);
    end
  endtask

  initial begin
    int seed;
    seed = $urandom(32'h5eed_1234);
    #3;
    chk(!busy_o && !done_o && !err_o, "R8 flags", {busy_o, done_o, err_o}, 0);
    chk(quo_o == '0 && rem_o == '0, "R8 data", int'(quo_o), 0);
    repeat (3) @(negedge clk_i);
    rst_ni = 1'b1;

    // directed corners
    run_op(0, 1, 1'b1, 1'b0, 1'b0);          // zero dividend, negative sign kept
    run_op(MAXV - 2, MAXV - 1, 1'b1, 1'b1, 1'b0);
    run_op(1, MAXV - 1, 1'b0, 1'b1, 1'b0);
    run_op(5, 0, 1'b0, 1'b0, 1'b0);          // zero divisor
    run_op(7, 7, 1'b0, 1'b1, 1'b0);          // equal
    run_op(20, 9, 1'b1, 1'b0, 1'b0);         // greater
    run_op(3, 8, 1'b1, 1'b0, 1'b1);          // R7 overlap
    run_op(11, 13, 1'b0, 1'b1, 1'b1);        // R7 overlap

    // R9: hold after done
    run_op(5, 12, 1'b1, 1'b0, 1'b0);
    repeat (4) @(negedge clk_i);
    chk(int'(quo_o[W-1:0]) == exp_q(5, 12) && quo_o[W] == 1'b1, "R9 hold quo",
        int'(quo_o), (1 << W) | exp_q(5, 12));
    chk(int'(rem_o) == exp_r(5, 12), "R9 hold rem", int'(rem_o), exp_r(5, 12));

    // exhaustive magnitudes with random signs
    for (int r = 0; r < MAXV; r++)
      for (int y = 0; y < MAXV; y++)
        run_op(r, y, 1'($urandom), 1'($urandom), 1'b0);

    // random mix with overlapping starts
    for (int k = 0; k < 300; k++)
      run_op(int'($urandom % MAXV), int'($urandom % MAXV), 1'($urandom), 1'($urandom),
             1'($urandom));

    finished = 1'b1;
    summary();
  end
endmodule